// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the programmable state of an I/O interrupt controller: one 64-bit redirection entry per interrupt pin, a 4-bit controller ID and a read-only version word. Software never addresses an entry directly. It writes an index into a select register, then reads or writes a 32-bit data window. Each entry is seen as two consecutive indices: the even index is the low word and the odd index is the high word.

The full table is driven out in parallel, so sensing and delivery logic can read any pin's configuration without using the bus. When a window write flips a pin's mask bit, the block emits a one-cycle pulse that carries the new mask value. When the written entry is level-triggered and the pin's pending input is high, the block emits a one-cycle re-evaluate strobe so that the delivery logic can service the pin again.

Entry layout relied on by neighbours: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], remote-IRR [14], trigger mode [15] (1 = level), mask [16], destination [63:56].

Top module: `irq_redir_regs`

## Requirements
- R1: A bus write of size 4 or 8 to offset 0x00 loads the 32-bit select register, and a read of offset 0x00 returns it. A read of offset 0x10 returns the indirect register named by the select value. Any other offset reads as zero.
- R2: Select value 0 holds the controller ID. A window write stores data bits 27:24, and a read returns the ID in bits 27:24 with all other bits zero. Select value 2 reads the same as select value 0, and writes through it are ignored.
- R3: Select value 1 reads as (PINS-1) in bits 23:16 and version code 0x11 in bits 7:0, with all other bits zero. Writes through it are ignored.
- R4: A select value s of 0x10 or above addresses entry (s-0x10)>>1. An odd s reaches bits 63:32 and an even s reaches bits 31:0. Entry n is driven on table_o[64n+63:64n].
- R5: A window write whose entry number is PINS or more changes nothing, and a window read of such a select value returns zero.
- R6: A write to an entry's low word clears that entry's remote-IRR bit 14, whatever value bit 14 of the data has. A pulse on rirr_set_i[n] sets that bit unless a window write to entry n happens in the same cycle. A write to the high word leaves the bit unchanged.
- R7: In the cycle after a window write that changes entry n's mask bit 16, mask_chg_o[n] is high for one cycle and mask_val_o[n] carries the new mask. A write that leaves the mask unchanged raises no pulse.
- R8: In the cycle after a window write to entry n, reeval_o[n] is high for one cycle when the updated entry has trigger bit 15 set and pend_i[n] was high during the write. It stays low otherwise.
- R9: Writes with a size other than 4 or 8 bytes are ignored. For accepted writes, only data bits 31:0 are used.
- R10: Reset sets every entry to mask=1 with all other bits zero, and clears the select register, the ID and all pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_off_i | input | 8 | Byte offset within the block |
| bus_size_i | input | 4 | Access size in bytes |
| bus_wdata_i | input | 64 | Write data (low 32 bits used) |
| bus_rdata_o | output | 32 | Read data, combinational from bus_off_i |
| pend_i | input | PINS | Pending level per pin from the sensing logic |
| rirr_set_i | input | PINS | Sets remote-IRR for a pin, from the delivery logic |
| table_o | output | 64*PINS | All redirection entries |
| mask_chg_o | output | PINS | Mask-change pulse per pin |
| mask_val_o | output | PINS | New mask value qualifying mask_chg_o |
| reeval_o | output | PINS | Re-evaluate strobe per pin |

## Verification
The bench writes a low word whose bit 14 is set and expects to read it back cleared. A design that copied the data straight through would fail that check, and so would one that cleared the bit on high-word writes. It targets select values just past the last entry, which catches an off-by-one bound that corrupts or aliases entry 0. It also sends writes through the version and arbitration-ID indices and expects no change. It sends writes of size 2 and of size 8 with a non-zero upper word, and checks that the first is dropped and that the second truncates to 32 bits. The pulse checks rewrite an unchanged mask, and write an edge-triggered entry with its pin pending, so that a pulse raised on every write is caught.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int unsigned ENTRY_W  = 64;
  localparam int unsigned HALF_W   = 32;
  localparam logic [7:0]  OFF_SEL  = 8'h00;
  localparam logic [7:0]  OFF_WIN  = 8'h10;
  localparam logic [31:0] IDX_ID   = 32'd0;
  localparam logic [31:0] IDX_VER  = 32'd1;
  localparam logic [31:0] IDX_ARB  = 32'd2;
  localparam logic [31:0] IDX_TBL  = 32'h10;
  localparam logic [7:0]  VER_CODE = 8'h11;
  localparam int unsigned RIRR_BIT = 14;
  localparam int unsigned TRIG_BIT = 15;
  localparam int unsigned MASK_BIT = 16;
  localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h1 << MASK_BIT;
endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
  import irq_redir_pkg::*;
#(
  parameter int unsigned PINS = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_we_i,
  input  logic [7:0]              bus_off_i,
  input  logic [3:0]              bus_size_i,
  input  logic [63:0]             bus_wdata_i,
  output logic [31:0]             bus_rdata_o,
  input  logic [PINS*ENTRY_W-1:0] table_i,
  output logic [PINS-1:0]         wr_lo_o,
  output logic [PINS-1:0]         wr_hi_o,
  output logic [HALF_W-1:0]       wdata_o
);
  localparam logic [7:0] VER_PINS = 8'(PINS - 1);

  logic [31:0] sel_q;
  logic [3:0]  id_q;
  logic        wr_ok, sel_wr, win_wr, in_tbl;
  logic [31:0] ent_num;
  logic [31:0] ind_rd;

  assign wr_ok   = bus_we_i && (bus_size_i == 4'd4 || bus_size_i == 4'd8);
  assign sel_wr  = wr_ok && bus_off_i == OFF_SEL;
  assign win_wr  = wr_ok && bus_off_i == OFF_WIN;
  assign wdata_o = bus_wdata_i[HALF_W-1:0];
  assign ent_num = (sel_q - IDX_TBL) >> 1;
  assign in_tbl  = sel_q >= IDX_TBL && ent_num < 32'(PINS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata_i[31:0];
      if (win_wr && sel_q == IDX_ID) id_q <= bus_wdata_i[27:24];
    end
  end

  always_comb begin
    wr_lo_o = '0;
    wr_hi_o = '0;
    for (int i = 0; i < PINS; i++) begin
      if (win_wr && in_tbl && ent_num == 32'(i)) begin
        wr_lo_o[i] = ~sel_q[0];
        wr_hi_o[i] = sel_q[0];
      end
    end
  end

  always_comb begin
    ind_rd = '0;
    if (sel_q == IDX_ID || sel_q == IDX_ARB) begin
      ind_rd[27:24] = id_q;
    end else if (sel_q == IDX_VER) begin
      ind_rd = {8'h00, VER_PINS, 8'h00, VER_CODE};
    end else if (in_tbl) begin
      for (int i = 0; i < PINS; i++) begin
        if (ent_num == 32'(i))
          ind_rd = sel_q[0] ? table_i[i*ENTRY_W+HALF_W +: HALF_W]
                            : table_i[i*ENTRY_W +: HALF_W];
      end
    end
  end

  always_comb begin
    unique case (bus_off_i)
      OFF_SEL: bus_rdata_o = sel_q;
      OFF_WIN: bus_rdata_o = ind_rd;
      default: bus_rdata_o = '0;
    endcase
  end

  p_sel_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_off_i == OFF_SEL) |=> $stable(sel_q));
  p_id_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_off_i == OFF_WIN && sel_q == IDX_ID) |=> $stable(id_q));
  p_one_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_lo_o | wr_hi_o));
  p_size_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_size_i == 4'd4 || bus_size_i == 4'd8) |-> (wr_lo_o | wr_hi_o) == '0);
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [HALF_W-1:0]  wdata_i,
  input  logic               rirr_set_i,
  input  logic               pend_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               mask_chg_o,
  output logic               mask_val_o,
  output logic               reeval_o
);
  logic [ENTRY_W-1:0] entry_q, entry_d;
  logic               wr;

  assign wr = wr_lo_i | wr_hi_i;

  always_comb begin
    entry_d = entry_q;
    if (wr_lo_i) begin
      entry_d[HALF_W-1:0] = wdata_i;
      entry_d[RIRR_BIT]   = 1'b0;
    end else if (wr_hi_i) begin
      entry_d[ENTRY_W-1:HALF_W] = wdata_i;
    end else if (rirr_set_i) begin
      entry_d[RIRR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q    <= ENTRY_RST;
      mask_chg_o <= 1'b0;
      mask_val_o <= 1'b1;
      reeval_o   <= 1'b0;
    end else begin
      entry_q    <= entry_d;
      mask_chg_o <= wr && (entry_d[MASK_BIT] != entry_q[MASK_BIT]);
      mask_val_o <= entry_d[MASK_BIT];
      reeval_o   <= wr && entry_d[TRIG_BIT] && pend_i;
    end
  end

  assign entry_o = entry_q;

  p_rirr_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> !entry_o[RIRR_BIT]);
  p_mask_val_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_chg_o |-> mask_val_o == entry_o[MASK_BIT]);
  p_mask_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> !mask_chg_o);
  p_reeval_lvl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reeval_o |-> entry_o[TRIG_BIT]);
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int unsigned PINS = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bus_we_i,
  input  logic [7:0]              bus_off_i,
  input  logic [3:0]              bus_size_i,
  input  logic [63:0]             bus_wdata_i,
  output logic [31:0]             bus_rdata_o,
  input  logic [PINS-1:0]         pend_i,
  input  logic [PINS-1:0]         rirr_set_i,
  output logic [PINS*ENTRY_W-1:0] table_o,
  output logic [PINS-1:0]         mask_chg_o,
  output logic [PINS-1:0]         mask_val_o,
  output logic [PINS-1:0]         reeval_o
);
  logic [PINS-1:0]   wr_lo, wr_hi;
  logic [HALF_W-1:0] wdata;

  irq_redir_decode #(.PINS(PINS)) u_dec (
    .clk_i, .rst_ni, .bus_we_i, .bus_off_i, .bus_size_i, .bus_wdata_i,
    .bus_rdata_o, .table_i(table_o), .wr_lo_o(wr_lo), .wr_hi_o(wr_hi),
    .wdata_o(wdata)
  );

  for (genvar g = 0; g < PINS; g++) begin : g_ent
    irq_redir_entry u_ent (
      .clk_i, .rst_ni,
      .wr_lo_i(wr_lo[g]), .wr_hi_i(wr_hi[g]), .wdata_i(wdata),
      .rirr_set_i(rirr_set_i[g]), .pend_i(pend_i[g]),
      .entry_o(table_o[g*ENTRY_W +: ENTRY_W]),
      .mask_chg_o(mask_chg_o[g]), .mask_val_o(mask_val_o[g]),
      .reeval_o(reeval_o[g])
    );
  end
endmodule

// File: tb/irq_redir_regs_test.sv
module irq_redir_regs_test;
  localparam int PINS = 24;

  logic clk = 0, rst_ni = 0;
  logic bus_we = 0;
  logic [7:0] bus_off = 0;
  logic [3:0] bus_size = 0;
  logic [63:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [PINS-1:0] pend = 0, rirr_set = 0;
  logic [PINS*64-1:0] tbl;
  logic [PINS-1:0] mchg, mval, reev;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_redir_regs #(.PINS(PINS)) uut (
    .clk_i(clk), .rst_ni, .bus_we_i(bus_we), .bus_off_i(bus_off),
    .bus_size_i(bus_size), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pend_i(pend), .rirr_set_i(rirr_set), .table_o(tbl),
    .mask_chg_o(mchg), .mask_val_o(mval), .reeval_o(reev)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  off;
    logic [3:0]  size;
    logic [63:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 4'd4, 64'h12,        32'h0,        4'd1},  // R1
    '{1'b0, 8'h00, 4'd4, 64'h0,         32'h12,       4'd1},
    '{1'b0, 8'h04, 4'd4, 64'h0,         32'h0,        4'd1},
    '{1'b0, 8'h20, 4'd4, 64'h0,         32'h0,        4'd1},
    '{1'b1, 8'h00, 4'd4, 64'h0,         32'h0,        4'd2},  // R2
    '{1'b1, 8'h10, 4'd4, 64'hFA000000,  32'h0,        4'd2},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h0A000000, 4'd2},
    '{1'b1, 8'h00, 4'd4, 64'h2,         32'h0,        4'd2},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h0A000000, 4'd2},
    '{1'b1, 8'h10, 4'd4, 64'h05000000,  32'h0,        4'd2},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h0A000000, 4'd2},
    '{1'b1, 8'h00, 4'd4, 64'h1,         32'h0,        4'd3},  // R3
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h00170011, 4'd3},
    '{1'b1, 8'h10, 4'd4, 64'hFFFFFFFF,  32'h0,        4'd3},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h00170011, 4'd3},
    '{1'b1, 8'h00, 4'd4, 64'h10,        32'h0,        4'd4},  // R4
    '{1'b1, 8'h10, 4'd4, 64'h00010055,  32'h0,        4'd4},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h00010055, 4'd4},
    '{1'b1, 8'h00, 4'd4, 64'h11,        32'h0,        4'd4},
    '{1'b1, 8'h10, 4'd4, 64'hAB000000,  32'h0,        4'd4},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'hAB000000, 4'd4},
    '{1'b1, 8'h00, 4'd4, 64'h3E,        32'h0,        4'd6},  // R6
    '{1'b1, 8'h10, 4'd4, 64'h12345678,  32'h0,        4'd6},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h12341678, 4'd6},
    '{1'b1, 8'h00, 4'd4, 64'h40,        32'h0,        4'd5},  // R5
    '{1'b1, 8'h10, 4'd4, 64'hDEAD,      32'h0,        4'd5},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h0,        4'd5},
    '{1'b1, 8'h00, 4'd4, 64'h10,        32'h0,        4'd9},  // R9
    '{1'b1, 8'h10, 4'd2, 64'h77,        32'h0,        4'd9},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h00010055, 4'd9},
    '{1'b1, 8'h10, 4'd8, 64'hFFFFFFFF_00010066, 32'h0, 4'd9},
    '{1'b0, 8'h10, 4'd4, 64'h0,         32'h00010066, 4'd9}
  };

  task automatic chk(input bit ok, input int req, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [3:0] sz, input logic [63:0] d);
    @(negedge clk);
    bus_we = 1; bus_off = off; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] off, input logic [31:0] exp, input int req);
    @(negedge clk);
    bus_off = off;
    #1;
    chk(bus_rdata == exp, req, 64'(bus_rdata), 64'(exp), "read");
  endtask

  task automatic chk_reset_state();
    for (int i = 0; i < PINS; i++)
      chk(tbl[i*64 +: 64] == 64'h10000, 10, tbl[i*64 +: 64], 64'h10000, "reset entry");  // R10
    chk(mchg == 0 && reev == 0, 10, 64'({mchg, reev}), 64'h0, "reset pulses");
    rd(8'h00, 32'h0, 10);
    rd(8'h10, 32'h0, 10);  // select 0 -> ID 0
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    chk_reset_state();

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) wr(VECS[v].off, VECS[v].size, VECS[v].data);
      else rd(VECS[v].off, VECS[v].exp, int'(VECS[v].req));
    end
    chk(tbl[63:0] == 64'hAB000000_00010066, 4, tbl[63:0], 64'hAB000000_00010066, "table_o entry0");
    chk(tbl[23*64 +: 64] == 64'h12341678, 4, tbl[23*64 +: 64], 64'h12341678, "table_o entry23");
    chk(tbl[1*64 +: 64] == 64'h10000, 5, tbl[1*64 +: 64], 64'h10000, "no alias from out-of-range");

    // R7: mask change pulse on entry 1
    wr(8'h00, 4'd4, 64'h12);
    wr(8'h10, 4'd4, 64'h00008031);
    chk(mchg == 24'h2 && mval[1] == 1'b0, 7, 64'(mchg), 64'h2, "mask pulse");
    @(negedge clk);
    chk(mchg == 0, 7, 64'(mchg), 64'h0, "mask pulse one cycle");
    wr(8'h10, 4'd4, 64'h00008031);
    chk(mchg == 0, 7, 64'(mchg), 64'h0, "no pulse when mask unchanged");
    wr(8'h10, 4'd4, 64'h00018031);
    chk(mchg == 24'h2 && mval[1] == 1'b1, 7, 64'({mchg[1], mval[1]}), 64'h3, "mask set pulse");

    // R8: re-evaluate strobe
    pend = 24'h6;
    wr(8'h00, 4'd4, 64'h13);
    wr(8'h10, 4'd4, 64'h0);
    chk(reev == 24'h2, 8, 64'(reev), 64'h2, "reeval level pending");
    @(negedge clk);
    chk(reev == 0, 8, 64'(reev), 64'h0, "reeval one cycle");
    wr(8'h00, 4'd4, 64'h14);
    wr(8'h10, 4'd4, 64'h00000040);
    chk(reev == 0, 8, 64'(reev), 64'h0, "no reeval edge");
    pend = 0;

    // R6: remote-IRR set / kept by high write / cleared by low write
    @(negedge clk); rirr_set = 24'h2;
    @(negedge clk); rirr_set = 0;
    chk(tbl[64+14] == 1'b1, 6, 64'(tbl[64+14]), 64'h1, "rirr set");
    wr(8'h00, 4'd4, 64'h13);
    wr(8'h10, 4'd4, 64'h0);
    chk(tbl[64+14] == 1'b1, 6, 64'(tbl[64+14]), 64'h1, "rirr kept by high write");
    wr(8'h00, 4'd4, 64'h12);
    wr(8'h10, 4'd4, 64'h0001C031);
    chk(tbl[64+14] == 1'b0, 6, 64'(tbl[64+14]), 64'h0, "rirr cleared by low write");

    // R10: reset mid-run
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    chk_reset_state();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule